// File: doc/BRIEF.md
# SDRAM Refresh Command Sequencer

This block sits on the controller side of a single-rank SDRAM command bus. It produces the commands that keep the memory refreshed. A periodic refresh request makes it issue one auto-refresh. A self-refresh entry request puts the device into its low-power self-refreshing state. A self-refresh exit request brings the device back out. While it owns the bus, the block raises `busy`, and the normal access path must then keep off the command pins. When `busy` is low, the access path may drive commands again.

The access path reports through `banks_idle` that every bank is closed and has met its precharge time. If that input is low when a request is accepted, the sequencer first issues a precharge-all. It then waits the precharge time before it refreshes. After an auto-refresh it holds the bus for the refresh cycle time. On exit from self refresh, CKE goes high first. The bus is then held for the refresh cycle time plus the self-refresh exit time. The three timing values are parameters in clock cycles, and one shared down-counter measures all of them. During refresh the device supplies the row address internally. For that reason only the A10 pin is driven here, and it is high only for the precharge-all.

Top module: `sdram_refresh_seq`

## Requirements
- R1: Reset state: while `rst_n` is low and in the first cycle after it, the bus shows NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1), with `cke`=1, `a10`=0 and `busy`=0. A reset asserted during a refresh or a self-refresh stay returns the block to this state.
- R2: When `ref_req` is accepted while `banks_idle` is 1, the following cycle drives auto-refresh: `cs_n`, `ras_n` and `cas_n` low, with `we_n` and `cke` high.
- R3: When a request is accepted while `banks_idle` is 0, the following cycle drives precharge-all: `cs_n`, `ras_n` and `we_n` low, `cas_n` high and `a10` high. The refresh or self-refresh entry command follows exactly T_RP cycles after the precharge-all cycle.
- R4: Every cycle after an auto-refresh drives NOP with `busy` high, until T_RFC cycles after the auto-refresh cycle. In that cycle `busy` returns low.
- R5: `busy` goes high in the same cycle that `ref_req` or `sr_enter_req` is accepted in the idle state. It stays high until the final timing wait ends.
- R6: An accepted `sr_enter_req` produces a self-refresh entry cycle: `cs_n`, `ras_n`, `cas_n` and `cke` low, with `we_n` high.
- R7: After self-refresh entry, `cke` stays low and the bus shows NOP until `sr_exit_req` is seen. `ref_req` and `sr_enter_req` have no effect during the stay.
- R8: The cycle after `sr_exit_req` is seen during self refresh, `cke` goes high. `busy` stays high with NOP for T_RFC+T_SREX cycles, counted from that first cycle with `cke` high, and then drops.
- R9: `sr_exit_req` outside self refresh is ignored: `busy` stays low, `cke` stays high and the bus shows NOP.
- R10: If `ref_req` and `sr_enter_req` are both asserted in the same idle cycle, the auto-refresh is carried out and the entry request is dropped.
- R11: `a10` is high only in precharge-all cycles. It is low for auto-refresh, self-refresh entry and NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_req | input | 1 | Request one auto-refresh (sampled when idle) |
| sr_enter_req | input | 1 | Request self-refresh entry (sampled when idle) |
| sr_exit_req | input | 1 | Request self-refresh exit (sampled in self refresh) |
| banks_idle | input | 1 | All banks closed and precharge time met |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| a10 | output | 1 | Address bit 10 (all-bank select for precharge) |
| busy | output | 1 | Sequencer owns the command bus |

## Verification
The command pins decode the state register directly. A wrong state therefore shows on the same cycle as a wrong command code, a wrong CKE level or a wrong `busy` level. A wrong counter load cannot be seen at once. It shows only when a wait ends, as `busy` dropping one or more cycles early or late, or as the refresh command moving off its T_RP slot. The bench compares every pin in every cycle, so any such shift is caught on the first cycle it moves.

// File: rtl/sdram_ref_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and command codes for the refresh sequencer.
// Assumes a single-rank command bus with active-low strobes.
package sdram_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREA     = 3'd1,
        ST_WAIT_RP  = 3'd2,
        ST_AREF     = 3'd3,
        ST_WAIT_RFC = 3'd4,
        ST_SRE      = 3'd5,
        ST_SELF     = 3'd6,
        ST_WAIT_SRX = 3'd7
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } bus_cmd_t;

    localparam bus_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam bus_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam bus_cmd_t CMD_REFR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/refresh_timer.sv
`timescale 1ns/1ps
// Module: refresh_timer
// One shared down-counter for every timing wait. A load sets the count,
// which then falls by one each cycle until it reaches zero.
// Assumes the caller loads only when entering a wait state.
module refresh_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load, else decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Wait is over when the count has run out.
    always_comb done = (cnt_q == '0);

endmodule

// File: rtl/refresh_fsm.sv
`timescale 1ns/1ps
// Module: refresh_fsm
// Sequences precharge-all, auto-refresh, self-refresh entry and exit, and
// works out the timer load for each wait. When a wait ends, the access path
// may issue its next command in the following idle cycle.
// Assumes T_RP >= 2 and T_RFC >= 2, with T_SREX >= 0.
module refresh_fsm
    import sdram_ref_pkg::*;
#(
    parameter int T_RP   = 3,
    parameter int T_RFC  = 6,
    parameter int T_SREX = 2,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_req,
    input  logic             sr_enter_req,
    input  logic             sr_exit_req,
    input  logic             banks_idle,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_t       state,
    output logic             busy
);

    // Wait states that follow a command hold for (T-1) cycles.
    // The exit wait starts on the first cycle with CKE high and lasts the full sum.
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 2);
    localparam logic [CNT_W-1:0] SRX_LD = CNT_W'(T_RFC + T_SREX - 1);

    seq_state_t state_q, state_d;
    logic       to_self_q, to_self_d;

    // Next-state, target and timer-load decisions.
    always_comb begin
        state_d   = state_q;
        to_self_d = to_self_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req) begin
                    to_self_d = 1'b0;
                    state_d   = banks_idle ? ST_AREF : ST_PREA;
                end else if (sr_enter_req) begin
                    to_self_d = 1'b1;
                    state_d   = banks_idle ? ST_SRE : ST_PREA;
                end
            end
            ST_PREA: begin
                state_d  = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = RP_LD;
            end
            ST_WAIT_RP: begin
                if (tmr_done) state_d = to_self_q ? ST_SRE : ST_AREF;
            end
            ST_AREF: begin
                state_d  = ST_WAIT_RFC;
                tmr_load = 1'b1;
                tmr_val  = RFC_LD;
            end
            ST_WAIT_RFC: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            ST_SRE: begin
                state_d = ST_SELF;
            end
            ST_SELF: begin
                if (sr_exit_req) begin
                    state_d  = ST_WAIT_SRX;
                    tmr_load = 1'b1;
                    tmr_val  = SRX_LD;
                end
            end
            ST_WAIT_SRX: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and pending-target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            to_self_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            to_self_q <= to_self_d;
        end
    end

    // Busy from the accepting cycle through the final wait.
    always_comb begin
        state = state_q;
        busy  = (state_q != ST_IDLE) || ref_req || sr_enter_req;
    end

endmodule

// File: rtl/refresh_cmd_enc.sv
`timescale 1ns/1ps
// Module: refresh_cmd_enc
// Decodes the sequencer state into the command pins, CKE and A10.
// Assumes NOP on every state that issues no command.
module refresh_cmd_enc
    import sdram_ref_pkg::*;
(
    input  seq_state_t state,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       cke,
    output logic       a10
);

    bus_cmd_t cmd;

    // Command code and CKE level for each state.
    always_comb begin
        cmd = CMD_NOP;
        a10 = 1'b0;
        cke = 1'b1;
        case (state)
            ST_PREA: begin
                cmd = CMD_PREA;
                a10 = 1'b1;
            end
            ST_AREF: cmd = CMD_REFR;
            ST_SRE: begin
                cmd = CMD_REFR;
                cke = 1'b0;
            end
            ST_SELF: cke = 1'b0;
            default: cmd = CMD_NOP;
        endcase
        {cs_n, ras_n, cas_n, we_n} = cmd;
    end

endmodule

// File: rtl/sdram_refresh_seq.sv
`timescale 1ns/1ps
// Module: sdram_refresh_seq (top)
// Refresh command sequencer for a single-rank SDRAM command bus.
// Assumes the access path drives banks_idle only once its precharges have
// met tRP, and that it keeps off the bus while busy is high.
module sdram_refresh_seq
    import sdram_ref_pkg::*;
#(
    parameter int T_RP   = 3,
    parameter int T_RFC  = 6,
    parameter int T_SREX = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_req,
    input  logic sr_enter_req,
    input  logic sr_exit_req,
    input  logic banks_idle,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke,
    output logic a10,
    output logic busy
);

    localparam int CNT_W = $clog2(T_RP + T_RFC + T_SREX + 1);

    seq_state_t       state;
    logic             tmr_load;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_val;

    refresh_fsm #(
        .T_RP(T_RP), .T_RFC(T_RFC), .T_SREX(T_SREX), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ref_req(ref_req), .sr_enter_req(sr_enter_req),
        .sr_exit_req(sr_exit_req), .banks_idle(banks_idle),
        .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .state(state), .busy(busy)
    );

    refresh_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    refresh_cmd_enc u_enc (
        .state(state),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .a10(a10)
    );

endmodule

// File: rtl/sdram_refresh_seq_chk.sv
`timescale 1ns/1ps
// Module: sdram_refresh_seq_chk
// Port-level protocol checks for the refresh sequencer, bound to the top.
module sdram_refresh_seq_chk #(
    parameter int T_RFC = 6
) (
    input logic clk,
    input logic rst_n,
    input logic sr_exit_req,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cke,
    input logic a10,
    input logic busy
);

    localparam int AGE_W = $clog2(T_RFC + 2);

    logic is_nop, is_refr, is_prea;
    logic [AGE_W-1:0] ref_age;

    // Command decode from the pins.
    always_comb begin
        is_nop  = !cs_n && ras_n && cas_n && we_n;
        is_refr = !cs_n && !ras_n && !cas_n && we_n;
        is_prea = !cs_n && !ras_n && cas_n && !we_n;
    end

    // Cycles since the last auto-refresh, saturating at T_RFC.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_age <= AGE_W'(T_RFC);
        else if (is_refr && cke) ref_age <= AGE_W'(1);
        else if (ref_age < AGE_W'(T_RFC)) ref_age <= ref_age + 1'b1;
    end

    assert_a10_prea_R11: assert property (@(posedge clk) disable iff (!rst_n)
        a10 |-> is_prea);

    assert_cke_fall_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> is_refr);

    assert_cke_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !sr_exit_req) |=> !cke);

    assert_cke_rise_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (busy && is_nop && ($past(sr_exit_req) || !$past(rst_n))));

    assert_rfc_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_age < AGE_W'(T_RFC)) |-> (busy && is_nop));

    assert_idle_keeps_cke_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> cke);

endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(.T_RFC(T_RFC)) u_chk (
    .clk(clk), .rst_n(rst_n), .sr_exit_req(sr_exit_req),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .a10(a10), .busy(busy)
);

// File: tb/sdram_refresh_seq_tb.sv
`timescale 1ns/1ps
// Bench: vector table walked cycle by cycle, then directed reset tests.
// Parameters are the defaults: T_RP=3, T_RFC=6, T_SREX=2.
module sdram_refresh_seq_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_req = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0, banks_idle = 1'b1;
    logic cs_n, ras_n, cas_n, we_n, cke, a10, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdram_refresh_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .ref_req(ref_req), .sr_enter_req(sr_enter_req),
        .sr_exit_req(sr_exit_req), .banks_idle(banks_idle),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .a10(a10), .busy(busy)
    );

    // Command codes {cs_n,ras_n,cas_n,we_n}
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] PRE = 4'b0010;

    // Vector: {repeat[4:0], in {ref,sre,srx,idle}[3:0], cmd[3:0], cke, a10, busy}
    localparam int NV = 30;
    localparam logic [15:0] VEC [NV] = '{
        {5'd1, 4'b0001, NOP, 3'b100},  // R1 idle after reset
        {5'd1, 4'b0011, NOP, 3'b100},  // R9 exit request while idle ignored
        {5'd1, 4'b1001, NOP, 3'b101},  // R5 busy on accept
        {5'd1, 4'b0001, REF, 3'b101},  // R2 auto-refresh, R11 a10 low
        {5'd5, 4'b0001, NOP, 3'b101},  // R4 recovery wait
        {5'd1, 4'b0001, NOP, 3'b100},  // R4 busy drops at AREF+T_RFC
        {5'd1, 4'b1000, NOP, 3'b101},  // R5 accept with banks open
        {5'd1, 4'b0000, PRE, 3'b111},  // R3 precharge-all with a10
        {5'd2, 4'b0001, NOP, 3'b101},  // R3 T_RP wait
        {5'd1, 4'b0001, REF, 3'b101},  // R3 refresh at PRE+T_RP
        {5'd5, 4'b0001, NOP, 3'b101},  // R4
        {5'd1, 4'b0001, NOP, 3'b100},  // R4
        {5'd1, 4'b1101, NOP, 3'b101},  // R10 both requests
        {5'd1, 4'b0001, REF, 3'b101},  // R10 refresh wins
        {5'd5, 4'b0001, NOP, 3'b101},  // R10 no entry afterwards
        {5'd1, 4'b0001, NOP, 3'b100},  // R10 back to idle, cke high
        {5'd1, 4'b0101, NOP, 3'b101},  // R5 entry accepted
        {5'd1, 4'b0001, REF, 3'b001},  // R6 self-refresh entry, cke low
        {5'd1, 4'b1001, NOP, 3'b001},  // R7 refresh request ignored
        {5'd2, 4'b0001, NOP, 3'b001},  // R7 cke held low
        {5'd1, 4'b0011, NOP, 3'b001},  // R8 exit request seen
        {5'd8, 4'b0001, NOP, 3'b101},  // R8 cke high, T_RFC+T_SREX wait
        {5'd1, 4'b0001, NOP, 3'b100},  // R8 busy drops
        {5'd1, 4'b0100, NOP, 3'b101},  // R5 entry with banks open
        {5'd1, 4'b0000, PRE, 3'b111},  // R3 precharge before entry
        {5'd2, 4'b0000, NOP, 3'b101},  // R3
        {5'd1, 4'b0000, REF, 3'b001},  // R3 R6 entry at PRE+T_RP
        {5'd1, 4'b0010, NOP, 3'b001},  // R8 immediate exit request
        {5'd8, 4'b0000, NOP, 3'b101},  // R8
        {5'd1, 4'b0000, NOP, 3'b100}   // R8
    };

    task automatic check(input string tag, input logic [3:0] ecmd,
                         input logic ecke, input logic ea10, input logic ebusy);
        logic [6:0] act, exp;
        act = {cs_n, ras_n, cas_n, we_n, cke, a10, busy};
        exp = {ecmd, ecke, ea10, ebusy};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {cmd,cke,a10,busy} actual %b expected %b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [3:0] in);
        {ref_req, sr_enter_req, sr_exit_req, banks_idle} = in;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #1 check("R1 in reset", NOP, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            for (int r = 0; r < int'(VEC[i][15:11]); r++) begin
                if (r != 0 || i != 0) @(negedge clk);
                drive(VEC[i][10:7]);
                #1 check($sformatf("vec %0d (see R-tag)", i),
                         VEC[i][6:3], VEC[i][2], VEC[i][1], VEC[i][0]);
            end
        end

        // R1 reset during refresh recovery
        @(negedge clk); drive(4'b1001);
        @(negedge clk); drive(4'b0001);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); #1 check("R1 reset during recovery", NOP, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1 reset during self refresh stay
        @(negedge clk); drive(4'b0101);
        @(negedge clk); drive(4'b0001);
        @(negedge clk); #1 check("R7 stay before reset", NOP, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); #1 check("R1 reset during self refresh", NOP, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); drive(4'b0011);
        #1 check("R9 exit after reset ignored", NOP, 1'b1, 1'b0, 1'b0);
        @(negedge clk); drive(4'b0001);
        #1 check("R9 still idle", NOP, 1'b1, 1'b0, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule